// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries out the register-level work a processor core performs when it enters an exception handler. The core presents one pending event together with a snapshot of the registers involved and pulses a start strobe. The event is a software break, a non-maskable interrupt, a bus fault, or an externally vectored interrupt. The block picks the vector and works out the return address, corrected for any branch delay slot that was in flight. It also works out the exception status word, the shifted condition-code word and the stack pointer swap. It then reads the handler address from a vector table in memory through a single-request read port.

When the read completes, all results are registered together in the same clock and a one-cycle done pulse tells the core to take them. A bus fault raised while a bus fault is already the active exception cannot be handled. In that case the block raises an abort pulse instead of starting an entry.

Top module: `exc_entry_seq`

## Requirements
- R1: The vector depends on the cause code (`cause_i`: 0 break, 1 non-maskable, 2 bus fault, 3 external interrupt). Break uses `trap_vec_i`, non-maskable uses vector 0, bus fault uses `fault_vec_i`, and external interrupt uses `irq_vec_i`.
- R2: Break, bus fault and external interrupt write the return address to `erp_o` and pass `nrp_i` unchanged to `nrp_o`. Non-maskable writes the return address to `nrp_o` and passes `erp_i` unchanged to `erp_o`.
- R3: `exs_o` carries the 8-bit vector in bits 15:8, and every other bit is zero.
- R4: The return address is `pc_i` minus `dslot_i`. `dslot_clr_o` pulses together with `done_o` exactly when `dslot_i` was nonzero.
- R5: The vector read asks for address `ebp_i + 4*vector`. `mem_req_o` stays high with a stable `mem_addr_o` until `mem_ack_i`, and `pc_o` takes `mem_rdata_i` from the acknowledged cycle.
- R6: If bit 8 (user mode) of `ccs_i` is set, `usp_o` takes `sp_i` and `sp_o` takes `ksp_i`. Otherwise both pass through unchanged.
- R7: `ccs_o` keeps bits 31:30 of the input, carries input bits 19:0 in bits 29:10, and has bits 9:0 zero. For a non-maskable event, input bit 9 is cleared before the shift, so `ccs_o[19]` is 0.
- R8: A bus fault start while `bf_active_i` is high gives a one-cycle `abort_o` in the next cycle, with no memory request, no busy and no done.
- R9: `busy_o` rises the cycle after an accepted start and falls with the one-cycle `done_o`. A start while busy is ignored, and the outputs reflect only the first event.
- R10: After reset, `busy_o`, `done_o`, `abort_o`, `mem_req_o` and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin an entry for the presented event |
| cause_i | input | 2 | Event cause code |
| bf_active_i | input | 1 | A bus fault is the currently active exception |
| pc_i | input | 32 | Current program counter |
| trap_vec_i | input | 8 | Break vector from the core |
| fault_vec_i | input | 8 | Vector latched at the translation miss |
| irq_vec_i | input | 8 | Vector from the interrupt controller |
| dslot_i | input | 2 | Pending delay-slot count |
| ccs_i | input | 32 | Condition-code/status word |
| sp_i | input | 32 | Current stack pointer |
| ksp_i | input | 32 | Kernel stack pointer |
| usp_i | input | 32 | User stack pointer register |
| erp_i | input | 32 | Current exception return register |
| nrp_i | input | 32 | Current non-maskable return register |
| ebp_i | input | 32 | Vector table base |
| mem_req_o | output | 1 | Vector read request |
| mem_addr_o | output | 32 | Vector read address |
| mem_ack_i | input | 1 | Read acknowledge, data valid |
| mem_rdata_i | input | 32 | Read data |
| busy_o | output | 1 | Entry in progress |
| done_o | output | 1 | Results valid this cycle |
| abort_o | output | 1 | Recursive bus fault detected |
| pc_o | output | 32 | Handler address |
| erp_o | output | 32 | New exception return register |
| nrp_o | output | 32 | New non-maskable return register |
| exs_o | output | 32 | New exception status word |
| ccs_o | output | 32 | New condition-code/status word |
| sp_o | output | 32 | New stack pointer |
| usp_o | output | 32 | New user stack pointer register |
| dslot_clr_o | output | 1 | Delay-slot state must be cleared |

## Verification
The assertions check the read-port protocol on every cycle: a pending request keeps its address until the acknowledge. They also check that done only follows an acknowledged read, that the status and condition words have their forced-zero bits, that the delay-slot clear only appears with done, and that abort never coincides with activity. Vector choice per cause, return-register routing, the delay-slot rewind, the stack swap, the M-flag clearing for non-maskable events and the ignoring of starts while busy are data-dependent. Only the bench's scenarios, compared against independently computed values, can show these.

// File: rtl/exc_entry_pkg.sv
// Shared constants and types for the exception entry sequencer.
// Assumes a 32-bit datapath; the status-word layout depends on it.
package exc_entry_pkg;
    localparam int XLEN      = 32;
    localparam int CCS_KEEP  = 2;   // top bits preserved in place
    localparam int CCS_SHIFT = 10;  // distance the lower field moves up
    localparam int EXS_POS   = 8;   // vector position in the status word

    typedef enum logic [1:0] {
        EV_BREAK  = 2'd0,
        EV_NMI    = 2'd1,
        EV_BUSFLT = 2'd2,
        EV_IRQ    = 2'd3
    } ev_cause_e;
endpackage

// File: rtl/exc_vec_select.sv
// Chooses the exception vector from the event cause.
// Assumes the non-maskable event is wired to vector zero.
module exc_vec_select
    import exc_entry_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  ev_cause_e          cause,
    input  logic [VEC_W-1:0]   trap_vec,
    input  logic [VEC_W-1:0]   fault_vec,
    input  logic [VEC_W-1:0]   irq_vec,
    output logic [VEC_W-1:0]   vec
);
    // Vector multiplexer keyed on cause.
    always_comb begin
        unique case (cause)
            EV_BREAK:  vec = trap_vec;
            EV_NMI:    vec = '0;
            EV_BUSFLT: vec = fault_vec;
            default:   vec = irq_vec;
        endcase
    end
endmodule

// File: rtl/exc_state_calc.sv
// Computes the register values written on exception entry from a
// captured snapshot. Purely combinational; the caller registers results.
// Assumes U_BIT and M_BIT lie inside the field that is shifted up.
module exc_state_calc
    import exc_entry_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int DS_W  = 2,
    parameter int U_BIT = 8,
    parameter int M_BIT = 9
) (
    input  logic               is_nmi,
    input  logic [VEC_W-1:0]   vec,
    input  logic [DS_W-1:0]    dslot,
    input  logic [XLEN-1:0]    pc,
    input  logic [XLEN-1:0]    erp,
    input  logic [XLEN-1:0]    nrp,
    input  logic [XLEN-1:0]    ccs,
    input  logic [XLEN-1:0]    sp,
    input  logic [XLEN-1:0]    ksp,
    input  logic [XLEN-1:0]    usp,
    output logic [XLEN-1:0]    erp_n,
    output logic [XLEN-1:0]    nrp_n,
    output logic [XLEN-1:0]    exs_n,
    output logic [XLEN-1:0]    ccs_n,
    output logic [XLEN-1:0]    sp_n,
    output logic [XLEN-1:0]    usp_n,
    output logic               ds_clr
);
    localparam int LOW_W = XLEN - CCS_KEEP - CCS_SHIFT;

    logic [XLEN-1:0] ret_addr;
    logic [XLEN-1:0] ccs_m;

    // Return address rewound by the pending delay-slot count.
    always_comb ret_addr = pc - XLEN'(dslot);

    // Route the return address to the register that belongs to the cause.
    always_comb begin
        erp_n = is_nmi ? erp : ret_addr;
        nrp_n = is_nmi ? ret_addr : nrp;
    end

    // Status word holds only the vector field.
    always_comb exs_n = XLEN'(vec) << EXS_POS;

    // Clear M for non-maskable events, then shift into saved position.
    always_comb begin
        ccs_m = ccs;
        if (is_nmi) ccs_m[M_BIT] = 1'b0;
        ccs_n = {ccs_m[XLEN-1 -: CCS_KEEP], ccs_m[LOW_W-1:0], {CCS_SHIFT{1'b0}}};
    end

    // Swap stacks when the core was in user mode.
    always_comb begin
        if (ccs[U_BIT]) begin
            usp_n = sp;
            sp_n  = ksp;
        end else begin
            usp_n = usp;
            sp_n  = sp;
        end
    end

    // Delay-slot state must be cleared when any count was pending.
    always_comb ds_clr = |dslot;
endmodule

// File: rtl/exc_vec_fetch.sv
// Single-outstanding vector-table read. The address is captured on
// launch and held with the request until the memory acknowledges.
// Assumes launch only arrives while no request is outstanding.
module exc_vec_fetch
    import exc_entry_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  logic [XLEN-1:0]    base,
    input  logic [VEC_W-1:0]   vec,
    input  logic               ack,
    output logic               req,
    output logic [XLEN-1:0]    addr,
    output logic               fire
);
    // Request and address register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req  <= 1'b0;
            addr <= '0;
        end else if (launch) begin
            req  <= 1'b1;
            addr <= base + (XLEN'(vec) << 2);
        end else if (req && ack) begin
            req  <= 1'b0;
        end
    end

    // Completion strobe for the parent.
    always_comb fire = req && ack;
endmodule

// File: rtl/exc_entry_seq.sv
// Exception entry sequencer top. Snapshots the event on start, issues
// the vector read, and writes all results together when it completes.
// Assumes the core holds no expectation of results before done_o.
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int DS_W  = 2,
    parameter int U_BIT = 8,
    parameter int M_BIT = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [1:0]         cause_i,
    input  logic               bf_active_i,
    input  logic [31:0]        pc_i,
    input  logic [VEC_W-1:0]   trap_vec_i,
    input  logic [VEC_W-1:0]   fault_vec_i,
    input  logic [VEC_W-1:0]   irq_vec_i,
    input  logic [DS_W-1:0]    dslot_i,
    input  logic [31:0]        ccs_i,
    input  logic [31:0]        sp_i,
    input  logic [31:0]        ksp_i,
    input  logic [31:0]        usp_i,
    input  logic [31:0]        erp_i,
    input  logic [31:0]        nrp_i,
    input  logic [31:0]        ebp_i,
    output logic               mem_req_o,
    output logic [31:0]        mem_addr_o,
    input  logic               mem_ack_i,
    input  logic [31:0]        mem_rdata_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               abort_o,
    output logic [31:0]        pc_o,
    output logic [31:0]        erp_o,
    output logic [31:0]        nrp_o,
    output logic [31:0]        exs_o,
    output logic [31:0]        ccs_o,
    output logic [31:0]        sp_o,
    output logic [31:0]        usp_o,
    output logic               dslot_clr_o
);
    ev_cause_e          cause_in;
    logic [VEC_W-1:0]   vec_live;
    logic               fatal;
    logic               accept;
    logic               fire;

    logic               busy_q;
    logic               nmi_q;
    logic [VEC_W-1:0]   vec_q;
    logic [DS_W-1:0]    ds_q;
    logic [XLEN-1:0]    pc_q, erp_q, nrp_q, ccs_q, sp_q, ksp_q, usp_q;

    logic [XLEN-1:0]    erp_n, nrp_n, exs_n, ccs_n, sp_n, usp_n;
    logic               ds_clr_n;

    // Decode the raw cause code.
    always_comb cause_in = ev_cause_e'(cause_i);

    // Recursive bus fault and accepted-start detection.
    always_comb begin
        fatal  = start_i && !busy_q && (cause_in == EV_BUSFLT) && bf_active_i;
        accept = start_i && !busy_q && !fatal;
    end

    exc_vec_select #(.VEC_W(VEC_W)) u_vsel (
        .cause     (cause_in),
        .trap_vec  (trap_vec_i),
        .fault_vec (fault_vec_i),
        .irq_vec   (irq_vec_i),
        .vec       (vec_live)
    );

    exc_vec_fetch #(.VEC_W(VEC_W)) u_fetch (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (accept),
        .base   (ebp_i),
        .vec    (vec_live),
        .ack    (mem_ack_i),
        .req    (mem_req_o),
        .addr   (mem_addr_o),
        .fire   (fire)
    );

    // Busy flag: set on accept, cleared when the read completes.
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_q <= 1'b0;
        else if (accept) busy_q <= 1'b1;
        else if (fire)   busy_q <= 1'b0;
    end

    // Event snapshot taken on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q <= 1'b0; vec_q <= '0; ds_q <= '0;
            pc_q <= '0; erp_q <= '0; nrp_q <= '0; ccs_q <= '0;
            sp_q <= '0; ksp_q <= '0; usp_q <= '0;
        end else if (accept) begin
            nmi_q <= (cause_in == EV_NMI);
            vec_q <= vec_live;
            ds_q  <= dslot_i;
            pc_q  <= pc_i;   erp_q <= erp_i;  nrp_q <= nrp_i;
            ccs_q <= ccs_i;  sp_q  <= sp_i;   ksp_q <= ksp_i;
            usp_q <= usp_i;
        end
    end

    exc_state_calc #(
        .VEC_W (VEC_W), .DS_W (DS_W), .U_BIT (U_BIT), .M_BIT (M_BIT)
    ) u_calc (
        .is_nmi (nmi_q), .vec (vec_q), .dslot (ds_q),
        .pc (pc_q), .erp (erp_q), .nrp (nrp_q), .ccs (ccs_q),
        .sp (sp_q), .ksp (ksp_q), .usp (usp_q),
        .erp_n (erp_n), .nrp_n (nrp_n), .exs_n (exs_n), .ccs_n (ccs_n),
        .sp_n (sp_n), .usp_n (usp_n), .ds_clr (ds_clr_n)
    );

    // Result registers, all written in the read-completion cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_o <= '0; erp_o <= '0; nrp_o <= '0; exs_o <= '0;
            ccs_o <= '0; sp_o <= '0; usp_o <= '0;
        end else if (fire) begin
            pc_o  <= mem_rdata_i;
            erp_o <= erp_n;  nrp_o <= nrp_n;  exs_o <= exs_n;
            ccs_o <= ccs_n;  sp_o  <= sp_n;   usp_o <= usp_n;
        end
    end

    // One-cycle strobes: done, delay-slot clear, abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o      <= 1'b0;
            dslot_clr_o <= 1'b0;
            abort_o     <= 1'b0;
        end else begin
            done_o      <= fire;
            dslot_clr_o <= fire && ds_clr_n;
            abort_o     <= fatal;
        end
    end

    // Busy is visible directly.
    always_comb busy_o = busy_q;
endmodule

// File: rtl/exc_entry_chk.sv
// Protocol and format checks for the exception entry sequencer,
// bound onto every instance of the top module.
module exc_entry_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy_o,
    input logic        done_o,
    input logic        abort_o,
    input logic        mem_req_o,
    input logic        mem_ack_i,
    input logic [31:0] mem_addr_o,
    input logic [31:0] exs_o,
    input logic [31:0] ccs_o,
    input logic        dslot_clr_o
);
    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

    // R9
    done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(mem_req_o && mem_ack_i) && !busy_o));

    // R3
    exs_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (exs_o[31:16] == 16'd0 && exs_o[7:0] == 8'd0));

    // R7
    ccs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (ccs_o[9:0] == 10'd0));

    // R8
    abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> (!busy_o && !mem_req_o && !done_o));

    // R4
    dsclr_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dslot_clr_o |-> done_o);
endmodule

bind exc_entry_seq exc_entry_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .abort_o     (abort_o),
    .mem_req_o   (mem_req_o),
    .mem_ack_i   (mem_ack_i),
    .mem_addr_o  (mem_addr_o),
    .exs_o       (exs_o),
    .ccs_o       (ccs_o),
    .dslot_clr_o (dslot_clr_o)
);

// File: tb/exc_entry_seq_bench.sv
// Scoreboard bench: the driver pushes expected results, the monitor
// pops and compares them when done_o appears.
module exc_entry_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  cause_i = '0;
    logic        bf_active_i = 1'b0;
    logic [31:0] pc_i = '0, ccs_i = '0, sp_i = '0, ksp_i = '0, usp_i = '0;
    logic [31:0] erp_i = '0, nrp_i = '0, ebp_i = '0;
    logic [7:0]  trap_vec_i = '0, fault_vec_i = '0, irq_vec_i = '0;
    logic [1:0]  dslot_i = '0;
    logic        mem_ack_i = 1'b0;
    logic [31:0] mem_rdata_i = '0;
    logic        mem_req_o, busy_o, done_o, abort_o, dslot_clr_o;
    logic [31:0] mem_addr_o, pc_o, erp_o, nrp_o, exs_o, ccs_o, sp_o, usp_o;

    int total = 0;
    int bad = 0;
    int lat = 0;
    bit finished = 0;

    typedef struct packed {
        logic [1:0]  cause;
        logic [31:0] pc, ccs, sp, ksp, usp, erp, nrp, ebp;
        logic [7:0]  tv, fv, iv;
        logic [1:0]  ds;
    } stim_t;

    typedef struct packed {
        logic [31:0] pc, erp, nrp, exs, ccs, sp, usp;
        logic        dsclr;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    exc_entry_seq u_exc_entry_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cause_i(cause_i),
        .bf_active_i(bf_active_i), .pc_i(pc_i), .trap_vec_i(trap_vec_i),
        .fault_vec_i(fault_vec_i), .irq_vec_i(irq_vec_i), .dslot_i(dslot_i),
        .ccs_i(ccs_i), .sp_i(sp_i), .ksp_i(ksp_i), .usp_i(usp_i),
        .erp_i(erp_i), .nrp_i(nrp_i), .ebp_i(ebp_i),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i),
        .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .done_o(done_o),
        .abort_o(abort_o), .pc_o(pc_o), .erp_o(erp_o), .nrp_o(nrp_o),
        .exs_o(exs_o), .ccs_o(ccs_o), .sp_o(sp_o), .usp_o(usp_o),
        .dslot_clr_o(dslot_clr_o)
    );

    function automatic logic [31:0] table_word(logic [31:0] a);
        return a ^ 32'h5A5A_C3C3;
    endfunction

    function automatic exp_t model(stim_t s);
        exp_t e;
        logic [7:0]  v;
        logic [31:0] ret, c;
        v = (s.cause == 2'd0) ? s.tv : (s.cause == 2'd1) ? 8'd0 :
            (s.cause == 2'd2) ? s.fv : s.iv;
        ret     = s.pc - {30'd0, s.ds};
        e.erp   = (s.cause == 2'd1) ? s.erp : ret;
        e.nrp   = (s.cause == 2'd1) ? ret : s.nrp;
        e.exs   = {16'd0, v, 8'd0};
        c       = s.ccs;
        if (s.cause == 2'd1) c[9] = 1'b0;
        e.ccs   = {c[31:30], c[19:0], 10'd0};
        e.sp    = s.ccs[8] ? s.ksp : s.sp;
        e.usp   = s.ccs[8] ? s.sp : s.usp;
        e.pc    = table_word(s.ebp + {22'd0, v, 2'b00});
        e.dsclr = (s.ds != 2'd0);
        return e;
    endfunction

    task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic apply(stim_t s);
        cause_i = s.cause; pc_i = s.pc; ccs_i = s.ccs; sp_i = s.sp;
        ksp_i = s.ksp; usp_i = s.usp; erp_i = s.erp; nrp_i = s.nrp;
        ebp_i = s.ebp; trap_vec_i = s.tv; fault_vec_i = s.fv;
        irq_vec_i = s.iv; dslot_i = s.ds;
    endtask

    task automatic run(stim_t s, int l);
        @(negedge clk);
        apply(s);
        lat = l;
        start_i = 1'b1;
        sb.push_back(model(s));
        @(negedge clk);
        start_i = 1'b0;
        chk("R9", "busy after start", {31'd0, busy_o}, 32'd1);
        while (busy_o) @(negedge clk);
    endtask

    // Memory responder: acknowledges after lat waiting cycles.
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            mem_ack_i = 1'b0;
            if (mem_req_o) begin
                if (cnt >= lat) begin
                    mem_ack_i   = 1'b1;
                    mem_rdata_i = table_word(mem_addr_o);
                    cnt = 0;
                end else cnt++;
            end else cnt = 0;
        end
    end

    // Monitor: compare results against the scoreboard on done.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && done_o) begin
                if (sb.size() == 0) begin
                    total++; bad++;
                    $display("FAIL R9 unexpected done actual=1 expected=0");
                end else begin
                    e = sb.pop_front();
                    chk("R1/R5", "handler pc", pc_o, e.pc);
                    chk("R2/R4", "erp", erp_o, e.erp);
                    chk("R2/R4", "nrp", nrp_o, e.nrp);
                    chk("R3", "exs", exs_o, e.exs);
                    chk("R7", "ccs", ccs_o, e.ccs);
                    chk("R6", "sp", sp_o, e.sp);
                    chk("R6", "usp", usp_o, e.usp);
                    chk("R4", "dslot clear", {31'd0, dslot_clr_o}, {31'd0, e.dsclr});
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        stim_t s;
        stim_t s2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10", "busy", {31'd0, busy_o}, 32'd0);
        chk("R10", "done", {31'd0, done_o}, 32'd0);
        chk("R10", "req", {31'd0, mem_req_o}, 32'd0);
        chk("R10", "abort", {31'd0, abort_o}, 32'd0);
        chk("R10", "pc", pc_o, 32'd0);
        chk("R10", "ccs", ccs_o, 32'd0);

        // R1 R2 break, kernel mode, no delay slot
        s = '{cause:2'd0, pc:32'h0000_1004, ccs:32'h0000_0A3F, sp:32'h8000_0F00,
              ksp:32'h9000_0000, usp:32'h7000_0000, erp:32'h1111_1111,
              nrp:32'h2222_2222, ebp:32'h4000_0000, tv:8'h1E, fv:8'h33,
              iv:8'h44, ds:2'd0};
        run(s, 0);

        // R2 R7 R6 R4 non-maskable, user mode with M set, one delay slot
        s = '{cause:2'd1, pc:32'h0000_2000, ccs:32'hC000_0300, sp:32'h8000_1000,
              ksp:32'h9000_2000, usp:32'h7000_3000, erp:32'h1234_5678,
              nrp:32'h0BAD_0BAD, ebp:32'h4000_0100, tv:8'h55, fv:8'h66,
              iv:8'h77, ds:2'd1};
        run(s, 2);

        // R1 R4 R6 bus fault, not recursive, two delay slots
        s = '{cause:2'd2, pc:32'h0000_3008, ccs:32'h4008_0100, sp:32'h8000_2000,
              ksp:32'h9000_4000, usp:32'h7000_5000, erp:32'h0,
              nrp:32'hFFFF_0000, ebp:32'h4000_0200, tv:8'h01, fv:8'h2C,
              iv:8'h03, ds:2'd2};
        run(s, 1);

        // R1 R7 external interrupt, vector 0xFF, table base wraps, all ones
        s = '{cause:2'd3, pc:32'h0000_0002, ccs:32'hFFFF_FFFF, sp:32'h1,
              ksp:32'h2, usp:32'h3, erp:32'h4, nrp:32'h5,
              ebp:32'hFFFF_FF00, tv:8'h10, fv:8'h20, iv:8'hFF, ds:2'd3};
        bf_active_i = 1'b1;   // does not matter for an external interrupt
        run(s, 3);
        bf_active_i = 1'b0;

        // R9 start while busy is ignored
        s = '{cause:2'd0, pc:32'h0000_5000, ccs:32'h0000_0000, sp:32'hA,
              ksp:32'hB, usp:32'hC, erp:32'hD, nrp:32'hE,
              ebp:32'h0001_0000, tv:8'h09, fv:8'h00, iv:8'h00, ds:2'd0};
        s2 = '{cause:2'd1, pc:32'h0000_6000, ccs:32'h0000_0100, sp:32'hF1,
               ksp:32'hF2, usp:32'hF3, erp:32'hF4, nrp:32'hF5,
               ebp:32'h0002_0000, tv:8'h0F, fv:8'h0F, iv:8'h0F, ds:2'd2};
        @(negedge clk);
        apply(s); lat = 5; start_i = 1'b1; sb.push_back(model(s));
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        apply(s2); start_i = 1'b1;   // arrives while busy
        @(negedge clk);
        start_i = 1'b0;
        chk("R9", "still busy", {31'd0, busy_o}, 32'd1);
        while (busy_o) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R9", "no second request", {31'd0, mem_req_o}, 32'd0);

        // R8 recursive bus fault
        s = '{cause:2'd2, pc:32'h0000_7000, ccs:32'h0, sp:32'h0, ksp:32'h0,
              usp:32'h0, erp:32'h0, nrp:32'h0, ebp:32'h0,
              tv:8'h0, fv:8'h12, iv:8'h0, ds:2'd0};
        @(negedge clk);
        apply(s); bf_active_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; bf_active_i = 1'b0;
        chk("R8", "abort pulse", {31'd0, abort_o}, 32'd1);
        chk("R8", "no busy", {31'd0, busy_o}, 32'd0);
        chk("R8", "no request", {31'd0, mem_req_o}, 32'd0);
        @(negedge clk);
        chk("R8", "abort one cycle", {31'd0, abort_o}, 32'd0);
        chk("R8", "still idle", {31'd0, busy_o}, 32'd0);

        repeat (4) @(negedge clk);
        chk("R9", "scoreboard drained", sb.size(), 32'd0);
        finish_run();
    end
endmodule